// File: doc/BRIEF.md
# Drift-Corrected Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value that advances once per clock. Each clock stands for one 16 ns time quantum, so while the counter runs it normally gains `QUANTUM_NS` per cycle. A drift engine trims the rate. Its packed word holds a period, a small magnitude and a direction. On every period-th quantum, the step becomes the nominal quantum plus or minus the magnitude.

Software uses a small word-wide register port. Through it, software can do four things:
- pause and resume the counter with command codes;
- preload the time in two 32-bit halves while the counter is paused;
- read the time as a low word followed by a high word;
- hold the drift engine in reset while it installs a new correction word.

Reading the low word also latches the high word into a shadow. The high-word read that follows therefore matches the low word, even when a carry crosses bit 32 between the two reads.

Top module: `tod_drift_counter`

## Requirements
- R1: After reset the time is 0, the counter is paused, the drift hold bit is 0, the drift word is 0 and `rd_data` is 0.
- R2: Writing 2 to the control word (address 0) pauses the counter and writing 4 resumes it. Any other value leaves the run state unchanged. Reading address 0 returns the run state in bit 0 (1 = running) and zeros elsewhere.
- R3: While the counter is running and no correction falls due, the time grows by exactly `QUANTUM_NS` (16) per clock.
- R4: While the counter is paused, the time does not change. In that state, a write to address 1 replaces time bits 31:0 and a write to address 2 replaces time bits 63:32. While the counter is running, writes to these two addresses are ignored.
- R5: Reading address 5 returns time bits 31:0 and, in the same cycle, copies time bits 63:32 into a shadow. Reading address 6 returns that shadow, so a low-then-high read pair stays coherent across a carry.
- R6: The drift word at address 3 has three fields. Bits 27:0 are the period in quanta. Bits 30:28 are the magnitude, 0 to 7 ns. Bit 31 is the direction: 1 adds the magnitude and 0 subtracts it. While the engine runs, every period-th running quantum steps by 16 plus or minus the magnitude.
- R7: A write to the drift word takes effect only while the drift hold bit (address 4, bit 0) is 1. Reading address 3 returns the stored word.
- R8: While the drift hold bit is 1, no correction is applied and the quanta count is cleared. After the bit is cleared, the first correction falls on the period-th running quantum.
- R9: A period field of 0 behaves as 1, so a correction is applied on every running quantum.
- R10: The drift engine counts quanta only while the time counter runs. A pause freezes its phase.
- R11: Read data is returned on `rd_data` one clock after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quantum clock, one edge per 16 ns quantum |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a coherent time read while a carry crosses bit 32 between the low and the high read. The bench reaches it by pausing the counter, preloading a low word 32 ns short of wrapping, and resuming. It then issues the low read and the high read with an idle cycle between them. Drift phase is the other hard case. It depends on how many running quanta have passed since the hold bit was released, including quanta lost to pauses. Directed sequences cover short periods in both directions and period 0. Seeded random traffic then mixes pauses, loads, hold toggles and new drift words, while a bench model follows each quantum.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W   = 32;
  localparam int TIME_W   = 2 * WORD_W;
  localparam int ADDR_W   = 3;
  localparam int PERIOD_W = 28;
  localparam int MAG_W    = 3;
  localparam int STEP_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_DRIFT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HOLD    = 3'd4;
  localparam logic [ADDR_W-1:0] A_TIME_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd6;

  localparam logic [WORD_W-1:0] CMD_PAUSE  = 32'd2;
  localparam logic [WORD_W-1:0] CMD_RESUME = 32'd4;

  typedef struct packed {
    logic                dir;
    logic [MAG_W-1:0]    mag;
    logic [PERIOD_W-1:0] period;
  } drift_cfg_t;

  function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
    return (p == '0) ? PERIOD_W'(1) : p;
  endfunction

  function automatic logic [STEP_W-1:0] step_calc(input logic fire, input drift_cfg_t cfg,
                                                  input int unsigned quantum);
    logic [STEP_W-1:0] base;
    base = STEP_W'(quantum);
    if (!fire)       return base;
    else if (cfg.dir) return base + STEP_W'(cfg.mag);
    else              return base - STEP_W'(cfg.mag);
  endfunction
endpackage

// File: rtl/tod_ctrl_regs.sv
module tod_ctrl_regs
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              running,
  output logic              drift_hold,
  output drift_cfg_t        cfg_q,
  output logic              ld_lo_we,
  output logic              ld_hi_we,
  output logic [WORD_W-1:0] ld_data
);
  logic ctrl_we, drift_we, hold_we;

  assign ctrl_we  = wr_en && (wr_addr == A_CTRL);
  assign drift_we = wr_en && (wr_addr == A_DRIFT) && drift_hold;
  assign hold_we  = wr_en && (wr_addr == A_HOLD);
  assign ld_lo_we = wr_en && (wr_addr == A_LOAD_LO) && !running;
  assign ld_hi_we = wr_en && (wr_addr == A_LOAD_HI) && !running;
  assign ld_data  = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      drift_hold <= 1'b0;
      cfg_q      <= '0;
    end else begin
      if (ctrl_we && wr_data == CMD_PAUSE)  running <= 1'b0;
      if (ctrl_we && wr_data == CMD_RESUME) running <= 1'b1;
      if (hold_we)  drift_hold <= wr_data[0];
      if (drift_we) cfg_q      <= drift_cfg_t'(wr_data);
    end
  end
endmodule

// File: rtl/tod_drift_engine.sv
module tod_drift_engine
  import tod_pkg::*;
#(
  parameter int unsigned QUANTUM_NS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              hold,
  input  drift_cfg_t        cfg,
  output logic              fire,
  output logic [STEP_W-1:0] step_ns
);
  logic [PERIOD_W-1:0] qcnt;
  logic [PERIOD_W-1:0] last_idx;

  assign last_idx = eff_period(cfg.period) - PERIOD_W'(1);
  assign fire     = advance && !hold && (qcnt == last_idx);
  assign step_ns  = step_calc(fire, cfg, QUANTUM_NS);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      qcnt <= '0;
    end else if (advance) begin
      qcnt <= fire ? '0 : qcnt + PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [STEP_W-1:0] step_ns,
  input  logic              ld_lo_we,
  input  logic              ld_hi_we,
  input  logic [WORD_W-1:0] ld_data,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (running) begin
      time_q <= time_q + TIME_W'(step_ns);
    end else begin
      if (ld_lo_we) time_q[WORD_W-1:0]      <= ld_data;
      if (ld_hi_we) time_q[TIME_W-1:WORD_W] <= ld_data;
    end
  end
endmodule

// File: rtl/tod_readback.sv
module tod_readback
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              running,
  input  logic              drift_hold,
  input  drift_cfg_t        cfg_q,
  input  logic [TIME_W-1:0] time_q,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] hi_shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      hi_shadow <= '0;
    end else if (rd_en) begin
      unique case (rd_addr)
        A_CTRL:    rd_data <= WORD_W'(running);
        A_DRIFT:   rd_data <= WORD_W'(cfg_q);
        A_HOLD:    rd_data <= WORD_W'(drift_hold);
        A_TIME_LO: begin
          rd_data   <= time_q[WORD_W-1:0];
          hi_shadow <= time_q[TIME_W-1:WORD_W];
        end
        A_TIME_HI: rd_data <= hi_shadow;
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_drift_counter.sv
module tod_drift_counter
  import tod_pkg::*;
#(
  parameter int unsigned QUANTUM_NS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic              running;
  logic              drift_hold;
  drift_cfg_t        cfg_q;
  logic              ld_lo_we;
  logic              ld_hi_we;
  logic [WORD_W-1:0] ld_data;
  logic              drift_fire;
  logic [STEP_W-1:0] step_ns;
  logic [TIME_W-1:0] time_q;

  tod_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .running(running), .drift_hold(drift_hold), .cfg_q(cfg_q),
    .ld_lo_we(ld_lo_we), .ld_hi_we(ld_hi_we), .ld_data(ld_data)
  );

  tod_drift_engine #(.QUANTUM_NS(QUANTUM_NS)) u_drift (
    .clk(clk), .rst_n(rst_n), .advance(running), .hold(drift_hold), .cfg(cfg_q),
    .fire(drift_fire), .step_ns(step_ns)
  );

  tod_time_core u_time (
    .clk(clk), .rst_n(rst_n), .running(running), .step_ns(step_ns),
    .ld_lo_we(ld_lo_we), .ld_hi_we(ld_hi_we), .ld_data(ld_data), .time_q(time_q)
  );

  tod_readback u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .running(running), .drift_hold(drift_hold), .cfg_q(cfg_q), .time_q(time_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/tod_drift_counter_chk.sv
module tod_drift_counter_chk
  import tod_pkg::*;
#(
  parameter int unsigned QUANTUM_NS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              running,
  input logic              drift_hold,
  input drift_cfg_t        cfg_q,
  input logic              ld_lo_we,
  input logic              ld_hi_we,
  input logic              drift_fire,
  input logic [TIME_W-1:0] time_q
);
  logic pause_cmd;
  assign pause_cmd = wr_en && (wr_addr == A_CTRL) && (wr_data == CMD_PAUSE);

  p_pause_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_cmd |=> !running);

  p_plain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !drift_fire) |=> (time_q == $past(time_q) + TIME_W'(QUANTUM_NS)));

  p_paused_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld_lo_we && !ld_hi_we) |=> $stable(time_q));

  p_add_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && drift_fire && cfg_q.dir) |=>
      (time_q == $past(time_q) + TIME_W'(QUANTUM_NS) + TIME_W'(cfg_q.mag)));

  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drift_hold |=> $stable(cfg_q));

  p_no_fire_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drift_hold |-> !drift_fire);

  p_no_fire_paused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !drift_fire);
endmodule

bind tod_drift_counter tod_drift_counter_chk #(.QUANTUM_NS(QUANTUM_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .running(running), .drift_hold(drift_hold), .cfg_q(cfg_q),
  .ld_lo_we(ld_lo_we), .ld_hi_we(ld_hi_we), .drift_fire(drift_fire), .time_q(time_q)
);

// File: tb/tb_tod_drift_counter.sv
module tb_tod_drift_counter;
  localparam int CLK_NS = 10;
  localparam int unsigned Q = 16;
  localparam int AC = 0, ALO = 1, AHI = 2, ADR = 3, AHD = 4, ATL = 5, ATH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  tod_drift_counter #(.QUANTUM_NS(Q)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Reference model, one quantum per posedge
  longint unsigned m_time, m_cnt;
  bit              m_run, m_hold;
  logic [31:0]     m_cfg, m_shadow, m_rd;

  function automatic longint unsigned bench_step(bit fire, logic [31:0] cfg);
    longint unsigned mag;
    mag = longint'(cfg[30:28]);
    if (!fire) return Q;
    return cfg[31] ? Q + mag : Q - mag;
  endfunction

  function automatic longint unsigned bench_period(logic [31:0] cfg);
    return (cfg[27:0] == 0) ? 1 : longint'(cfg[27:0]);
  endfunction

  always @(posedge clk) begin
    bit              fire;
    longint unsigned nt;
    if (!rst_n) begin
      m_time = 0; m_cnt = 0; m_run = 0; m_hold = 0;
      m_cfg = 0; m_shadow = 0; m_rd = 0;
    end else begin
      fire = 0;
      if (m_run && !m_hold) begin
        if (m_cnt == bench_period(m_cfg) - 1) begin fire = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      if (m_hold) m_cnt = 0;
      nt = m_time;
      if (m_run) nt = m_time + bench_step(fire, m_cfg);
      else if (wr_en && wr_addr == ALO) nt = {m_time[63:32], wr_data};
      else if (wr_en && wr_addr == AHI) nt = {wr_data, m_time[31:0]};
      if (rd_en) begin
        case (rd_addr)
          AC:  m_rd = {31'd0, m_run};
          ADR: m_rd = m_cfg;
          AHD: m_rd = {31'd0, m_hold};
          ATL: begin m_rd = m_time[31:0]; m_shadow = m_time[63:32]; end
          ATH: m_rd = m_shadow;
          default: m_rd = 0;
        endcase
      end
      if (wr_en && wr_addr == AC && wr_data == 2) m_run = 0;
      if (wr_en && wr_addr == AC && wr_data == 4) m_run = 1;
      if (wr_en && wr_addr == ADR && m_hold) m_cfg = wr_data;
      if (wr_en && wr_addr == AHD) m_hold = wr_data[0];
      m_time = nt;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit w, int wa, logic [31:0] wd, bit r, int ra, string tag);
    wr_en = w; wr_addr = wa[2:0]; wr_data = wd;
    rd_en = r; rd_addr = ra[2:0];
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check(tag, rd_data, m_rd);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    op(1, a, d, 0, 0, tag);
  endtask

  task automatic rd(int a, string tag);
    op(0, 0, 0, 1, a, tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", rd_data, 32'h0);
    rd(AC, "R1");  check("R1", rd_data, 32'h0);
    rd(ADR, "R1"); check("R1", rd_data, 32'h0);
    rd(AHD, "R1"); check("R1", rd_data, 32'h0);
    rd(ATL, "R1"); check("R1", rd_data, 32'h0);
    // R2 control codes
    wr(AC, 32'd7, "R2"); rd(AC, "R2"); check("R2", rd_data, 32'h0);
    wr(AC, 32'd4, "R2"); rd(AC, "R2"); check("R2", rd_data, 32'h1);
    wr(AC, 32'd6, "R2"); rd(AC, "R2"); check("R2", rd_data, 32'h1);
    // R3 plain stepping
    rd(ATL, "R3"); rd(ATL, "R3"); rd(ATL, "R3");
    // R4 loads ignored while running, accepted while paused
    wr(ALO, 32'h1234_0000, "R4"); rd(ATL, "R4");
    wr(AC, 32'd2, "R4");
    wr(ALO, 32'hFFFF_FFE0, "R4"); wr(AHI, 32'h5, "R4");
    rd(ATL, "R4"); check("R4", rd_data, 32'hFFFF_FFE0);
    op(0, 0, 0, 0, 0, "R4"); rd(ATL, "R4"); check("R4", rd_data, 32'hFFFF_FFE0);
    // R5 coherent pair across a carry (drift word is 0)
    wr(AC, 32'd4, "R5");
    rd(ATL, "R5"); check("R5", rd_data, 32'hFFFF_FFE0);
    op(0, 0, 0, 0, 0, "R5");
    rd(ATH, "R5"); check("R5", rd_data, 32'h5);
    rd(ATL, "R5"); rd(ATH, "R5"); check("R5", rd_data, 32'h6);
    // R11 read data holds
    repeat (3) op(0, 0, 0, 0, 0, "R11");
    check("R11", rd_data, 32'h6);
    // R7 locked writes
    wr(ADR, 32'h8000_0003, "R7"); rd(ADR, "R7"); check("R7", rd_data, 32'h0);
    wr(AHD, 32'h1, "R7"); rd(AHD, "R7"); check("R7", rd_data, 32'h1);
    wr(ADR, 32'hD000_0003, "R7"); rd(ADR, "R7"); check("R7", rd_data, 32'hD000_0003);
    // R8 no correction while held
    repeat (4) rd(ATL, "R8");
    // R6 add 5 ns every 3rd quantum
    wr(AHD, 32'h0, "R6");
    repeat (8) rd(ATL, "R6");
    // R10 pause freezes phase
    wr(AC, 32'd2, "R10"); repeat (3) rd(ATL, "R10");
    wr(AC, 32'd4, "R10"); repeat (5) rd(ATL, "R10");
    // R6 subtract 7 ns every 2nd quantum
    wr(AHD, 32'h1, "R6"); wr(ADR, 32'h7000_0002, "R6"); wr(AHD, 32'h0, "R6");
    repeat (6) rd(ATL, "R6");
    // R9 period 0 subtracts 2 every quantum
    wr(AHD, 32'h1, "R9"); wr(ADR, 32'h2000_0000, "R9"); wr(AHD, 32'h0, "R9");
    rd(ATL, "R9");
    begin
      logic [31:0] a;
      a = rd_data;
      rd(ATL, "R9"); check("R9", rd_data, a + 32'd14);
    end
    // Seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if      (k < 30) rd(ATL, "R5");
      else if (k < 48) rd(ATH, "R5");
      else if (k < 52) rd(AC, "R2");
      else if (k < 57) wr(AC, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 7)) :
                              (($urandom_range(0, 1) == 0) ? 32'd2 : 32'd4), "R2");
      else if (k < 62) wr(ALO, $urandom, "R4");
      else if (k < 66) wr(AHI, $urandom, "R4");
      else if (k < 74) wr(AHD, 32'($urandom_range(0, 1)), "R8");
      else if (k < 84) wr(ADR, {1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                                28'($urandom_range(0, 6))}, "R7");
      else if (k < 88) rd(ADR, "R7");
      else if (k < 90) rd(AHD, "R8");
      else             op(0, 0, 0, 0, 0, "R11");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule